// File: doc/BRIEF.md
# Touch Burst Filter

This block post-processes the sample stream of a resistive touch digitiser. The digitiser delivers bursts of up to four packed 32-bit sample words. Each word carries a 10-bit X reading, a 10-bit Y reading and a pen-level bit. The filter gathers one burst and emits one report per burst. The report carries a filtered X and Y position and a touch flag that says whether the position can be trusted.

Words arrive on a valid/ready stream. A separate `burst_end` strobe closes the burst; it may fall on the same cycle as the last word or on a cycle of its own. An `in_ovr` flag marks the burst as corrupted by an upstream FIFO overrun. Both axes are inverted so that the reported range runs the other way. Only the second and third samples feed the position, because the first and last samples are the noisiest while the pen settles or lifts. A report only counts as a touch when the burst was complete and the pen was still down on its final sample.

Top module: `touch_burst_filter`

## Requirements
- R1: After reset is released, `in_ready` is 1 on every cycle, and a word is taken on every cycle in which `in_valid` is 1.
- R2: When `burst_end` is 1 in a cycle and no overrun was flagged in that burst, `rep_valid` is 1 for exactly the one following cycle. Otherwise `rep_valid` is 0.
- R3: Each axis is inverted as 1023 minus its 10-bit field. X is taken from word bits 25:16 and Y from word bits 9:0.
- R4: On a touch report, each axis equals the sum of the inverted values of the second and third words of the burst (word indices 1 and 2), computed in 11 bits and shifted right by one. Any remainder is dropped.
- R5: `rep_touch` is 1 only when four words were gathered and bit 31 of the fourth word is 0. Bit 31 set to 1 means the pen is up.
- R6: A burst that closes with fewer than four words, including a burst with no words, gives a report with `rep_touch` equal to 0.
- R7: If `in_ovr` is 1 in any cycle of a burst, up to and including its `burst_end` cycle, that burst gives no report. The following burst is filtered normally.
- R8: When a report has `rep_touch` equal to 0, `rep_x` and `rep_y` keep their previous values.
- R9: Words after the fourth in a burst are ignored. A five-word burst reports the same as its first four words.
- R10: The word count, the stored words and the overrun mark are cleared at every burst end, so no data carries over into the next burst.
- R11: During and right after reset, `rep_valid`, `rep_touch`, `rep_x` and `rep_y` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample word present |
| in_ready | output | 1 | Filter accepts a word |
| in_data | input | 32 | Packed sample: pen bit 31, X 25:16, Y 9:0 |
| burst_end | input | 1 | Closes the current burst (may share a cycle with the last word) |
| in_ovr | input | 1 | Upstream overrun, discard the current burst |
| rep_valid | output | 1 | One-cycle report strobe |
| rep_x | output | 10 | Filtered, inverted X position |
| rep_y | output | 10 | Filtered, inverted Y position |
| rep_touch | output | 1 | Report is a valid pen-down touch |

## Verification
Several properties are checked on every cycle:
- the report strobe follows each clean burst end and appears nowhere else;
- an overrun suppresses the report;
- a short burst never raises the touch flag;
- a non-touch report leaves the position unchanged;
- the word counter stays bounded and clears after each burst end.

Only the bench scenarios can show the arithmetic: the inversion, which words feed the average and the truncation of the average. The same holds for dropping a fifth word, for the pen-up decision on the fourth word, and for the clean start of the burst after an overrun or a short burst.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  localparam int COORD_W = 10;
  typedef logic [COORD_W-1:0] coord_t;
  typedef struct packed {
    coord_t x;
    coord_t y;
  } point_t;
endpackage

// File: rtl/tbf_collect.sv
module tbf_collect
  import tbf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SAMPLES = 4,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int KEEP_A  = 1,
  parameter int KEEP_B  = 2,
  localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              burst_end,
  input  logic              ovr,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  eff_cnt,
  output point_t            eff_a,
  output point_t            eff_b,
  output logic              eff_pen,
  output logic              eff_ovr
);
  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             pen_q;
  logic             ovr_q;
  logic             last_hit;
  point_t           cur;
  point_t           kept [2];
  logic             unused_bits;

  assign unused_bits = ^data;
  assign take     = beat && (cnt < CNT_W'(SAMPLES));
  assign cur      = '{x: data[X_LSB +: COORD_W], y: data[Y_LSB +: COORD_W]};
  assign last_hit = take && (cnt == CNT_W'(SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst || burst_end) cnt <= '0;
    else if (take)        cnt <= cnt + CNT_W'(1);
  end

  // only the two averaged words are stored, as coordinate fields
  for (genvar k = 0; k < 2; k++) begin : g_keep
    localparam int IDX = (k == 0) ? KEEP_A : KEEP_B;
    logic   hit;
    point_t q;
    assign hit = take && (cnt == CNT_W'(IDX));
    always_ff @(posedge clk) begin
      if (rst || burst_end) q <= '0;
      else if (hit)         q <= cur;
    end
    assign kept[k] = hit ? cur : q;
  end

  always_ff @(posedge clk) begin
    if (rst || burst_end) pen_q <= 1'b0;
    else if (last_hit)    pen_q <= data[PEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst || burst_end) ovr_q <= 1'b0;
    else if (ovr)         ovr_q <= 1'b1;
  end

  assign eff_a   = kept[0];
  assign eff_b   = kept[1];
  assign eff_pen = last_hit ? data[PEN_BIT] : pen_q;
  assign eff_ovr = ovr_q | ovr;
  assign eff_cnt = cnt + CNT_W'(take);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(SAMPLES));
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(burst_end) |-> (cnt == '0));
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovr && !burst_end) |=> eff_ovr);
endmodule

// File: rtl/tbf_axis_avg.sv
module tbf_axis_avg #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] avg
);
  logic [W:0] sum;
  // inversion against all-ones is a bitwise complement
  assign sum = {1'b0, ~a} + {1'b0, ~b};
  assign avg = sum[W:1];
endmodule

// File: rtl/touch_burst_filter.sv
module touch_burst_filter
  import tbf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SAMPLES = 4,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              burst_end,
  input  logic              in_ovr,
  output logic              rep_valid,
  output logic [COORD_W-1:0] rep_x,
  output logic [COORD_W-1:0] rep_y,
  output logic              rep_touch
);
  logic             rdy_q;
  logic [CNT_W-1:0] eff_cnt;
  point_t           eff_a, eff_b;
  logic             eff_pen, eff_ovr;
  logic             fire, full_down;
  coord_t           ax_a [2];
  coord_t           ax_b [2];
  coord_t           ax_avg [2];

  assign in_ready = rdy_q;

  tbf_collect #(
    .DATA_W(DATA_W), .SAMPLES(SAMPLES), .X_LSB(X_LSB), .Y_LSB(Y_LSB),
    .PEN_BIT(PEN_BIT), .KEEP_A(1), .KEEP_B(2)
  ) u_collect (
    .clk(clk), .rst(rst), .beat(in_valid && rdy_q), .burst_end(burst_end),
    .ovr(in_ovr), .data(in_data), .eff_cnt(eff_cnt), .eff_a(eff_a),
    .eff_b(eff_b), .eff_pen(eff_pen), .eff_ovr(eff_ovr)
  );

  assign ax_a[0] = eff_a.x;
  assign ax_b[0] = eff_b.x;
  assign ax_a[1] = eff_a.y;
  assign ax_b[1] = eff_b.y;

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    tbf_axis_avg #(.W(COORD_W)) u_avg (
      .a(ax_a[ax]), .b(ax_b[ax]), .avg(ax_avg[ax])
    );
  end

  assign fire      = burst_end && !eff_ovr;
  assign full_down = (eff_cnt == CNT_W'(SAMPLES)) && !eff_pen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      rep_valid <= 1'b0;
      rep_touch <= 1'b0;
      rep_x     <= '0;
      rep_y     <= '0;
    end else begin
      rdy_q     <= 1'b1;
      rep_valid <= fire;
      if (fire) rep_touch <= full_down;
      if (fire && full_down) begin
        rep_x <= ax_avg[0];
        rep_y <= ax_avg[1];
      end
    end
  end

  p_ready_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready);
  p_report_r2: assert property (@(posedge clk) disable iff (rst)
    (burst_end && !eff_ovr) |=> rep_valid);
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> $past(burst_end));
  p_drop_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    (burst_end && eff_ovr) |=> !rep_valid);
  p_short_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && eff_cnt != CNT_W'(SAMPLES)) |=> !rep_touch);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && !rep_touch) |-> ($stable(rep_x) && $stable(rep_y)));
endmodule

// File: tb/touch_burst_filter_test.sv
module touch_burst_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        burst_end = 1'b0;
  logic        in_ovr = 1'b0;
  logic        rep_valid;
  logic [9:0]  rep_x, rep_y;
  logic        rep_touch;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] bw [0:7];
  int exp_x = 0;
  int exp_y = 0;

  always #2 clk = ~clk;

  touch_burst_filter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .burst_end(burst_end), .in_ovr(in_ovr),
    .rep_valid(rep_valid), .rep_x(rep_x), .rep_y(rep_y), .rep_touch(rep_touch)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int inv_x(input logic [31:0] w);
    return 1023 - int'(w[25:16]);
  endfunction
  function automatic int inv_y(input logic [31:0] w);
    return 1023 - int'(w[9:0]);
  endfunction

  // drives one burst from bw[0..n-1]; caller is at a negedge
  task automatic run_burst(input int n, input int ovr_pos, input bit end_alone);
    bit sep = end_alone || (n == 0);
    bit ovr_any = (ovr_pos >= 0) && ((ovr_pos < n) || (sep && ovr_pos == n));
    int cnt = (n > 4) ? 4 : n;
    bit tch = (cnt == 4) && !bw[3][31];
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = bw[i]; in_ovr = (i == ovr_pos);
      burst_end = !sep && (i == n - 1);
      @(negedge clk);
    end
    if (sep) begin
      in_valid = 1'b0; burst_end = 1'b1; in_ovr = (ovr_pos == n);
      @(negedge clk);
    end
    in_valid = 1'b0; burst_end = 1'b0; in_ovr = 1'b0;
    if (ovr_any) begin
      check(rep_valid == 1'b0, "R7 dropped", int'(rep_valid), 0);
    end else begin
      check(rep_valid == 1'b1, "R2 strobe", int'(rep_valid), 1);
      if (cnt < 4) check(rep_touch == 1'b0, "R6 short", int'(rep_touch), 0);
      else check(rep_touch == tch, "R5 touch", int'(rep_touch), int'(tch));
      if (tch) begin
        exp_x = (inv_x(bw[1]) + inv_x(bw[2])) / 2;
        exp_y = (inv_y(bw[1]) + inv_y(bw[2])) / 2;
        check(int'(rep_x) == exp_x, "R3 R4 x", int'(rep_x), exp_x);
        check(int'(rep_y) == exp_y, "R3 R4 y", int'(rep_y), exp_y);
      end else begin
        check(int'(rep_x) == exp_x, "R8 hold x", int'(rep_x), exp_x);
        check(int'(rep_y) == exp_y, "R8 hold y", int'(rep_y), exp_y);
      end
    end
    @(negedge clk);
    check(rep_valid == 1'b0, "R2 single cycle", int'(rep_valid), 0);
  endtask

  function automatic logic [31:0] mk(input bit pen, input int x, input int y);
    return {pen, 5'd0, 10'(x), 6'd0, 10'(y)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(rep_valid == 0, "R11 valid", int'(rep_valid), 0);
    check(rep_touch == 0, "R11 touch", int'(rep_touch), 0);
    check(rep_x == 0 && rep_y == 0, "R11 pos", int'(rep_x), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

    // full touch with boundary values: (1023+1022)/2 truncates to 1022
    bw[0] = mk(0, 500, 500); bw[1] = mk(0, 0, 1023);
    bw[2] = mk(0, 1, 1023);  bw[3] = mk(0, 7, 7);
    run_burst(4, -1, 0);
    check(rep_x == 10'd1022 && rep_y == 10'd0, "R4 truncation", int'(rep_x), 1022);

    // pen up on fourth word: R5, R8
    bw[3] = mk(1, 7, 7); bw[1] = mk(0, 100, 200);
    run_burst(4, -1, 1);
    // short burst: R6
    run_burst(3, -1, 0);
    // empty burst: R6
    run_burst(0, -1, 1);
    // overrun on end cycle, then clean burst: R7
    bw[3] = mk(0, 9, 9);
    run_burst(2, 2, 1);
    run_burst(4, -1, 0);
    // fifth word ignored: R9
    bw[1] = mk(0, 300, 40); bw[2] = mk(0, 301, 41); bw[4] = mk(1, 1023, 0);
    run_burst(5, -1, 0);
    // clean start after a three-word burst: R10
    run_burst(3, -1, 0);
    bw[1] = mk(0, 10, 20); bw[2] = mk(0, 30, 40);
    run_burst(4, -1, 0);
    check(rep_touch == 1'b1, "R10 fresh burst", int'(rep_touch), 1);

    // random mix
    for (int t = 0; t < 300; t++) begin
      int n = $urandom_range(0, 6);
      int op = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 6) : -1;
      bit sep = $urandom_range(0, 1);
      for (int i = 0; i < 8; i++)
        bw[i] = mk($urandom_range(0, 3) == 0, $urandom_range(0, 1023), $urandom_range(0, 1023));
      run_burst(n, op, sep);
      if ($urandom_range(0, 1)) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule